// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a watchdog timer peripheral on a simple two-phase register bus. A 32-bit down-counter counts toward zero while counting is enabled. At zero it sets a sticky status flag. It can also raise any of three outputs: a system-reset request, an interrupt and an external signal. Each output has its own enable bit, and each one stays high for a programmable number of bus clock cycles. Software keeps the system alive by writing one exact key word to the restart register. That write copies the reload value back into the counter, and any other value written there does nothing.

The counter steps either once per bus clock or once per rising edge of a slower external clock. The external clock is resynchronised into the bus clock domain and used as a count tick. Its period must be more than twice the bus clock period. The asynchronous active-low reset input is released through a two-stage synchroniser. All internal state therefore leaves reset two bus clock edges after the input rises.

Top module: `wdog_top`

## Requirements
- R1: Register offsets are: counter 0x00 (read-only), reload 0x04, restart 0x08, control 0x0C, status 0x10, clear 0x14, pulse length 0x18. After reset these read as follows: reload 0x03EF1480, pulse length 0xFF, control 0, status 0 and counter 0. All three outputs are low after reset.
- R2: Control bit 0 enables counting. A change of that bit from 0 to 1 loads the counter from the reload register. While enabled, the counter drops by one per count tick. While disabled, it holds its value.
- R3: When the counter steps from 1 to 0, status bit 0 is set. The counter then holds at 0, and the outputs fire only once, until the counter is reloaded.
- R4: A bus write of the full 32-bit word 0x00005AB9 to the restart register loads the counter from the reload register. A write of any other value to that register leaves the counter unchanged. This includes 0x00005AB8 and 0x00015AB9.
- R5: A write with bit 0 set to the clear register clears status bit 0. A write with bit 0 at 0 leaves the status unchanged.
- R6: An output is asserted at a timeout only if its enable bit in the control register is set. Bit 1 enables the reset request, bit 2 the interrupt and bit 3 the external signal.
- R7: Each enabled output stays high for exactly as many bus clock cycles as the pulse-length register holds. A pulse length of 0 produces no pulse.
- R8: Control bit 4 selects the count tick. At 0 the counter ticks on every bus clock. At 1 it ticks only on rising edges of ext_clk, and it does not count while ext_clk is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 8 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from paddr |
| ext_clk | input | 1 | Slow external count clock |
| sys_rst_req | output | 1 | Timeout reset request pulse |
| irq | output | 1 | Timeout interrupt pulse |
| ext_sig | output | 1 | Timeout external signal pulse |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit addresses, 8-bit pulse length and the one-second reload reset value. That reset value is read back directly. Because the reload register is writable, the bench then programs short reload values of 4 to 1000 ticks, so each timeout falls within a few hundred cycles. The 8-bit pulse-length register allows the bench to check widths of 0, 1 and 5 cycles and to confirm the 0xFF reset value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_COUNT   = 8'h00;
  localparam logic [7:0] OFF_RELOAD  = 8'h04;
  localparam logic [7:0] OFF_RESTART = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_STATUS  = 8'h10;
  localparam logic [7:0] OFF_CLEAR   = 8'h14;
  localparam logic [7:0] OFF_PLEN    = 8'h18;

  localparam logic [31:0] RESTART_KEY = 32'h0000_5AB9;

  localparam int CTRL_W     = 5;
  localparam int CB_EN      = 0;
  localparam int CB_OUT0    = 1;
  localparam int CB_CLKSEL  = 4;
  localparam int N_OUTS     = 3;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int LW = 8,
  parameter logic [DW-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [LW-1:0] PLEN_RST   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [AW-1:0]     paddr,
  input  logic [DW-1:0]     pwdata,
  input  logic [DW-1:0]     cnt,
  input  logic              fire,
  output logic [DW-1:0]     prdata,
  output logic [DW-1:0]     reload_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [LW-1:0]     plen_q,
  output logic              status_q,
  output logic              restart_hit,
  output logic              clr_hit
);
  logic              wr;
  logic [DW-1:0]     reload_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic [LW-1:0]     plen_d;
  logic              status_d;

  assign wr          = psel && penable && pwrite;
  assign restart_hit = wr && (paddr == AW'(OFF_RESTART)) && (pwdata == DW'(RESTART_KEY));
  assign clr_hit     = wr && (paddr == AW'(OFF_CLEAR)) && pwdata[0];

  always_comb begin
    reload_d = reload_q;
    ctrl_d   = ctrl_q;
    plen_d   = plen_q;
    if (wr && paddr == AW'(OFF_RELOAD)) reload_d = pwdata;
    if (wr && paddr == AW'(OFF_CTRL))   ctrl_d   = pwdata[CTRL_W-1:0];
    if (wr && paddr == AW'(OFF_PLEN))   plen_d   = pwdata[LW-1:0];
    if (fire)         status_d = 1'b1;
    else if (clr_hit) status_d = 1'b0;
    else              status_d = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      ctrl_q   <= '0;
      plen_q   <= PLEN_RST;
      status_q <= 1'b0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
      plen_q   <= plen_d;
      status_q <= status_d;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      AW'(OFF_COUNT):  prdata = cnt;
      AW'(OFF_RELOAD): prdata = reload_q;
      AW'(OFF_CTRL):   prdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      AW'(OFF_STATUS): prdata = {{(DW-1){1'b0}}, status_q};
      AW'(OFF_PLEN):   prdata = {{(DW-LW){1'b0}}, plen_q};
      default:         prdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clk_sel,
  input  logic          ext_clk,
  input  logic          restart,
  input  logic [DW-1:0] reload,
  output logic [DW-1:0] cnt_q,
  output logic          fire_q,
  output logic          tick
);
  logic [2:0]    ext_sync_q;
  logic          ext_rise;
  logic          en_d_q;
  logic          load;
  logic          step;
  logic [DW-1:0] cnt_d;
  logic          fire_d;

  assign ext_rise = ext_sync_q[1] && !ext_sync_q[2];
  assign tick     = clk_sel ? ext_rise : 1'b1;
  assign load     = restart || (en && !en_d_q);
  assign step     = en && tick && (cnt_q != '0);

  always_comb begin
    if (load)      cnt_d = reload;
    else if (step) cnt_d = cnt_q - DW'(1);
    else           cnt_d = cnt_q;
    fire_d = !load && step && (cnt_q == DW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync_q <= '0;
      en_d_q     <= 1'b0;
      cnt_q      <= '0;
      fire_q     <= 1'b0;
    end else begin
      ext_sync_q <= {ext_sync_q[1:0], ext_clk};
      en_d_q     <= en;
      cnt_q      <= cnt_d;
      fire_q     <= fire_d;
    end
  end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [LW-1:0] len,
  output logic          pulse
);
  logic [LW-1:0] left_q;
  logic [LW-1:0] left_d;

  always_comb begin
    if (trig)                left_d = len;
    else if (left_q != '0)   left_d = left_q - LW'(1);
    else                     left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int LW = 8,
  parameter logic [DW-1:0] RELOAD_RST = 32'h03EF1480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic          ext_clk,
  output logic          sys_rst_req,
  output logic          irq,
  output logic          ext_sig
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DW-1:0]     cnt_q;
  logic              fire;
  logic              tick;
  logic [DW-1:0]     reload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LW-1:0]     plen_q;
  logic              status_q;
  logic              restart_hit;
  logic              clr_hit;
  logic [N_OUTS-1:0] pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  wdog_regs #(.DW(DW), .AW(AW), .LW(LW), .RELOAD_RST(RELOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata),
    .cnt(cnt_q), .fire(fire),
    .prdata(prdata), .reload_q(reload_q), .ctrl_q(ctrl_q),
    .plen_q(plen_q), .status_q(status_q),
    .restart_hit(restart_hit), .clr_hit(clr_hit)
  );

  wdog_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .en(ctrl_q[CB_EN]), .clk_sel(ctrl_q[CB_CLKSEL]),
    .ext_clk(ext_clk), .restart(restart_hit), .reload(reload_q),
    .cnt_q(cnt_q), .fire_q(fire), .tick(tick)
  );

  for (genvar i = 0; i < N_OUTS; i++) begin : g_out
    wdog_stretch #(.LW(LW)) u_str (
      .clk(clk), .rst_n(rst_sync_n),
      .trig(fire && ctrl_q[CB_OUT0+i]),
      .len(plen_q),
      .pulse(pulses[i])
    );
  end

  assign sys_rst_req = pulses[0];
  assign irq         = pulses[1];
  assign ext_sig     = pulses[2];
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic [DW-1:0] cnt,
  input logic          en,
  input logic          tick,
  input logic          restart_hit,
  input logic          fire,
  input logic          status,
  input logic          clr_hit,
  input logic          irq,
  input logic          irq_en
);
  logic bad_key;
  assign bad_key = psel && penable && pwrite && (paddr == AW'(OFF_RESTART))
                   && (pwdata != DW'(RESTART_KEY));

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !restart_hit && tick && cnt != '0) |=> (cnt == $past(cnt) - DW'(1))); // R2

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !restart_hit && cnt == '0) |=> (cnt == '0)); // R3

  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> status); // R3

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_key && en && $past(en) && !tick) |=> $stable(cnt)); // R4

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !fire) |=> !status); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire && irq_en)); // R6
endmodule

bind wdog_top wdog_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata),
  .cnt(cnt_q), .en(ctrl_q[0]), .tick(tick),
  .restart_hit(restart_hit), .fire(fire), .status(status_q),
  .clr_hit(clr_hit), .irq(irq), .irq_en(ctrl_q[2])
);

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;
  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        ext_clk;
  logic        sys_rst_req, irq, ext_sig;
  logic        ext_run;
  int          vectors;
  int          miscompares;

  wdog_top u_wdog_top (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_clk(ext_clk),
    .sys_rst_req(sys_rst_req), .irq(irq), .ext_sig(ext_sig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    ext_clk = 1'b0;
    forever begin
      #50;
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input logic ok, input logic [31:0] act,
                          input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 outputs low", {29'd0, sys_rst_req, irq, ext_sig}, 32'd0);
    bus_rd(8'h04, d); chk("R1 reload reset", d, 32'h03EF1480);
    bus_rd(8'h18, d); chk("R1 plen reset", d, 32'h000000FF);
    bus_rd(8'h0C, d); chk("R1 ctrl reset", d, 32'd0);
    bus_rd(8'h10, d); chk("R1 status reset", d, 32'd0);
    bus_rd(8'h00, d); chk("R1 counter reset", d, 32'd0);
  endtask

  task automatic t_count_hold;
    logic [31:0] a, b;
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h04, 32'd1000);
    bus_wr(8'h0C, 32'h1);
    idle(20);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h00, a);
    chk_true("R2 counting from reload", (a < 32'd1000) && (a > 32'd950), a, 32'd980);
    idle(20);
    bus_rd(8'h00, b);
    chk("R2 hold while disabled", b, a);
  endtask

  // Runs one timeout; which = 1..3 selects control bit, width measured per output
  task automatic t_timeout(input int which, input logic [7:0] len, input string req);
    int w0, w1, w2;
    logic [31:0] d;
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h14, 32'h1);
    bus_wr(8'h18, {24'd0, len});
    bus_wr(8'h04, 32'd10);
    bus_wr(8'h0C, 32'h1 | (32'h1 << which));
    w0 = 0; w1 = 0; w2 = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sys_rst_req) w0++;
      if (irq)         w1++;
      if (ext_sig)     w2++;
    end
    chk({req, " rst width"}, w0, (which == 1) ? len : 0);
    chk({req, " irq width"}, w1, (which == 2) ? len : 0);
    chk({req, " ext width"}, w2, (which == 3) ? len : 0);
    bus_rd(8'h10, d); chk("R3 status set", d, 32'd1);
    bus_rd(8'h00, d); chk("R3 counter holds at zero", d, 32'd0);
  endtask

  task automatic t_key_clear;
    logic [31:0] d;
    bus_wr(8'h04, 32'd100);
    bus_wr(8'h08, 32'h0000_5AB8);
    idle(3);
    bus_rd(8'h00, d); chk("R4 wrong key ignored", d, 32'd0);
    bus_wr(8'h08, 32'h0001_5AB9);
    idle(3);
    bus_rd(8'h00, d); chk("R4 key upper bits ignored", d, 32'd0);
    bus_wr(8'h08, 32'h0000_5AB9);
    bus_rd(8'h00, d);
    chk_true("R4 key restarts", (d <= 32'd100) && (d >= 32'd90), d, 32'd97);
    bus_wr(8'h14, 32'h0000_0002);
    bus_rd(8'h10, d); chk("R5 clear bit0=0 keeps status", d, 32'd1);
    bus_wr(8'h14, 32'h0000_0001);
    bus_rd(8'h10, d); chk("R5 clear bit0=1 clears", d, 32'd0);
  endtask

  task automatic t_ext_clock;
    logic [31:0] d;
    int t;
    bit seen;
    ext_run = 1'b0;
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h14, 32'h1);
    bus_wr(8'h18, 32'd4);
    bus_wr(8'h04, 32'd4);
    bus_wr(8'h0C, 32'h15);
    idle(30);
    bus_rd(8'h00, d); chk("R8 no ticks while ext idle", d, 32'd4);
    ext_run = 1'b1;
    t = 0; seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk);
      t++;
      if (irq) seen = 1;
    end
    chk("R8 timeout on ext clock", {31'd0, seen}, 32'd1);
    chk_true("R8 ext tick rate", t >= 25, t, 32'd40);
    ext_run = 1'b0;
  endtask

  initial begin
    vectors = 0; miscompares = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    ext_run = 1'b0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_count_hold();
    t_timeout(1, 8'd5, "R6 R7 reset out");
    t_timeout(2, 8'd5, "R6 R7 irq out");
    t_timeout(3, 8'd5, "R6 R7 ext out");
    t_timeout(2, 8'd1, "R7 len one");
    t_timeout(2, 8'd0, "R7 len zero");
    t_key_clear();
    t_ext_clock();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule